// File: doc/BRIEF.md
# Sixteen-Line Interrupt Request Latch Bank

This block collects sixteen interrupt request lines into one pending vector. Nine lines come from outside the chip. They are active-low and asynchronous. Each is brought into the clock domain through a synchroniser. A single shared mode input decides how all of these outside lines are captured:

- In edge mode, only a falling transition raises a request.
- In level mode, a low line raises a request on every clock for as long as it stays low.

The other seven lines come from on-chip logic. They are active-high and always level-sensitive.

Once a pending bit is set, it stays set until it is cleared. A clear can name single bits or can take the whole vector at once. Software can also set pending bits directly through a write port. One bit position is reserved for the software-call request, and a software write to that bit only takes effect when a compatibility input allows it. Masking, priority encoding and fault capture are handled elsewhere; this block only delivers the pending vector to them.

The default line map puts outside lines at bit 0 and bits 8 to 15. Bits 1 to 7 are on-chip lines. Bit 5 is the software-call position.

Top module: `irq_latch_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pending` is all zeros.
- R2: In level mode (`edge_mode`=0), an outside line held low sets its pending bit on the third rising clock edge after the fall. After that bit is cleared, it is set again on the very next edge if the line is still low.
- R3: In edge mode (`edge_mode`=1), a falling transition on an outside line sets its pending bit on the third rising edge. A line that stays low after its bit is cleared does not set the bit again. A later high-then-low transition does set it again.
- R4: In edge mode, a falling transition that arrives while the line's pending bit is still set is discarded, not remembered. Clearing the bit afterwards leaves it at 0.
- R5: On-chip lines (bits 1 to 7, active-high) set their pending bit on the next rising edge, whatever the value of `edge_mode`. They set it again on every edge while they stay high.
- R6: A one in `clr_bit` clears the matching pending bit on the next edge. The other bits are left as they were.
- R7: When `clr_all` is high, every pending bit is zero after the next edge.
- R8: If a clear and a set land on the same bit in the same cycle, the clear wins and the bit is 0. The set can come from a hardware line or from software.
- R9: When `sw_set_valid` is high, the ones in `sw_set_bits` are ORed into `pending` on the next edge.
- R10: A software write to bit 5 is dropped unless `sw_call_en` is 1.
- R11: `ext_irq_n` at on-chip positions (bits 1 to 7) has no effect on `pending`. `int_irq` at outside positions (bits 0 and 8 to 15) has no effect on `pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq_n | input | 16 | Raw outside request lines, active low, asynchronous; only the outside positions are used |
| int_irq | input | 16 | On-chip request lines, active high, synchronous; only the on-chip positions are used |
| edge_mode | input | 1 | 1 = edge capture for outside lines, 0 = level capture |
| clr_bit | input | 16 | Clears the selected pending bits |
| clr_all | input | 1 | Clears the whole pending vector |
| sw_set_valid | input | 1 | Qualifies a software set write |
| sw_set_bits | input | 16 | Bits to OR into the pending vector |
| sw_call_en | input | 1 | Allows a software set of bit 5 |
| pending | output | 16 | Pending interrupt vector |

## Verification
The assertions assume that `int_irq` and all control inputs change only in step with `clk`. They make no assumption about the outside lines, whose timing is only tied to the pending vector through the synchroniser delay. The bench drives every input on the falling clock edge. Each outside pulse is held for at least three cycles, which stands in for the minimum-width rule on the analog pin. Clears and software writes are single-cycle pulses that are always released before the next stimulus, so the property windows never overlap an unrelated write.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam int NUM_LINES    = 16;
    localparam int SW_CALL_BIT  = 5;

    typedef logic [NUM_LINES-1:0] irq_vec_t;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    typedef struct packed {
        logic     valid;
        irq_vec_t bits;
    } sw_set_t;

    typedef struct packed {
        irq_vec_t lvl;   // synchronised line is active
        irq_vec_t fall;  // synchronised line has just gone active
    } ext_obs_t;

    // Default map: outside lines at bit 0 and bits 15..8
    localparam irq_vec_t EXT_LINES_DEFAULT = 16'hFF01;

    function automatic irq_vec_t sw_gate(input sw_set_t wr, input logic call_en);
        irq_vec_t keep;
        keep = '1;
        if (!call_en) begin
            keep[SW_CALL_BIT] = 1'b0;
        end
        return wr.valid ? (wr.bits & keep) : '0;
    endfunction

    function automatic irq_vec_t clear_mask(input irq_vec_t bits, input logic all);
        return bits | {NUM_LINES{all}};
    endfunction

endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync
    import irq_latch_pkg::*;
#(
    parameter irq_vec_t EXT_LINES = EXT_LINES_DEFAULT,
    parameter int       STAGES    = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t line_n,
    output ext_obs_t obs
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (EXT_LINES[i]) begin : g_ext
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '1;
                    prev_q  <= 1'b1;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], line_n[i]};
                    prev_q  <= chain_q[LAST];
                end
            end

            assign obs.lvl[i]  = ~chain_q[LAST];
            assign obs.fall[i] = prev_q & ~chain_q[LAST];
        end else begin : g_int
            assign obs.lvl[i]  = 1'b0;
            assign obs.fall[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_req_select.sv
module irq_req_select
    import irq_latch_pkg::*;
#(
    parameter irq_vec_t EXT_LINES = EXT_LINES_DEFAULT
) (
    input  ext_obs_t obs,
    input  irq_vec_t int_lvl,
    input  sense_e   sense,
    output irq_vec_t hw_req
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
        if (EXT_LINES[i]) begin : g_ext
            assign hw_req[i] = (sense == SENSE_EDGE) ? obs.fall[i] : obs.lvl[i];
        end else begin : g_int
            assign hw_req[i] = int_lvl[i];
        end
    end

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_latch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t hw_req,
    input  sw_set_t  sw_wr,
    input  logic     call_en,
    input  irq_vec_t clr_bits,
    input  logic     clr_every,
    output irq_vec_t pend
);

    irq_vec_t set_vec;
    irq_vec_t clr_vec;
    irq_vec_t pend_q;

    always_comb begin
        set_vec = hw_req | sw_gate(sw_wr, call_en);
        clr_vec = clear_mask(clr_bits, clr_every);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | set_vec) & ~clr_vec;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_latch_pkg::*;
#(
    parameter irq_vec_t EXT_LINES   = EXT_LINES_DEFAULT,
    parameter int       SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] ext_irq_n,
    input  logic [NUM_LINES-1:0] int_irq,
    input  logic                 edge_mode,
    input  logic [NUM_LINES-1:0] clr_bit,
    input  logic                 clr_all,
    input  logic                 sw_set_valid,
    input  logic [NUM_LINES-1:0] sw_set_bits,
    input  logic                 sw_call_en,
    output logic [NUM_LINES-1:0] pending
);

    ext_obs_t obs;
    irq_vec_t hw_req;
    sw_set_t  sw_wr;
    sense_e   sense;

    assign sense = edge_mode ? SENSE_EDGE : SENSE_LEVEL;
    assign sw_wr = '{valid: sw_set_valid, bits: sw_set_bits};

    irq_ext_sync #(
        .EXT_LINES (EXT_LINES),
        .STAGES    (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .line_n (ext_irq_n),
        .obs    (obs)
    );

    irq_req_select #(
        .EXT_LINES (EXT_LINES)
    ) sel_i (
        .obs     (obs),
        .int_lvl (int_irq),
        .sense   (sense),
        .hw_req  (hw_req)
    );

    irq_pend_reg pend_i (
        .clk       (clk),
        .rst       (rst),
        .hw_req    (hw_req),
        .sw_wr     (sw_wr),
        .call_en   (sw_call_en),
        .clr_bits  (clr_bit),
        .clr_every (clr_all),
        .pend      (pending)
    );

endmodule

// File: rtl/irq_latch_bank_chk.sv
module irq_latch_bank_chk
    import irq_latch_pkg::*;
#(
    parameter irq_vec_t EXT_LINES = EXT_LINES_DEFAULT
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] int_irq,
    input logic [NUM_LINES-1:0] clr_bit,
    input logic                 clr_all,
    input logic                 sw_set_valid,
    input logic [NUM_LINES-1:0] sw_set_bits,
    input logic                 sw_call_en,
    input logic [NUM_LINES-1:0] pending
);

    localparam irq_vec_t INT_LINES = ~EXT_LINES;

    // R7: global clear empties the vector
    a_r7_global_clear: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (pending == '0));

    // R6: every selected bit is zero after a per-bit clear
    a_r6_bit_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_bit != '0) |=> ((pending & $past(clr_bit)) == '0));

    // R8: a clear beats a software set of the same bit
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (sw_set_valid && ((sw_set_bits & clr_bit) != '0))
        |=> ((pending & $past(sw_set_bits & clr_bit)) == '0));

    // R9: uncleared software bits (bit 5 excepted) appear on the next edge
    a_r9_sw_set: assert property (@(posedge clk) disable iff (rst)
        (sw_set_valid && !clr_all)
        |=> ((pending & ($past(sw_set_bits & ~clr_bit) & ~(16'h1 << SW_CALL_BIT)))
             == ($past(sw_set_bits & ~clr_bit) & ~(16'h1 << SW_CALL_BIT))));

    // R11/R5: on-chip bits only rise from their own line or a software write
    a_r11_int_source: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & INT_LINES)
         & ~($past(int_irq) | ($past(sw_set_valid) ? $past(sw_set_bits) : '0))) == '0);

    // R10: bit 5 cannot rise from a software write while the call enable is low
    a_r10_call_gate: assert property (@(posedge clk) disable iff (rst)
        ($rose(pending[SW_CALL_BIT]) && !$past(int_irq[SW_CALL_BIT]))
        |-> ($past(sw_set_valid) && $past(sw_call_en)));

endmodule

bind irq_latch_bank irq_latch_bank_chk #(.EXT_LINES(EXT_LINES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .int_irq      (int_irq),
    .clr_bit      (clr_bit),
    .clr_all      (clr_all),
    .sw_set_valid (sw_set_valid),
    .sw_set_bits  (sw_set_bits),
    .sw_call_en   (sw_call_en),
    .pending      (pending)
);

// File: tb/irq_latch_bank_tb_top.sv
module irq_latch_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ext_irq_n = '1;
    logic [15:0] int_irq = '0;
    logic        edge_mode = 1'b0;
    logic [15:0] clr_bit = '0;
    logic        clr_all = 1'b0;
    logic        sw_set_valid = 1'b0;
    logic [15:0] sw_set_bits = '0;
    logic        sw_call_en = 1'b0;
    logic [15:0] pending;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_latch_bank dut_i (
        .clk          (clk),
        .rst          (rst),
        .ext_irq_n    (ext_irq_n),
        .int_irq      (int_irq),
        .edge_mode    (edge_mode),
        .clr_bit      (clr_bit),
        .clr_all      (clr_all),
        .sw_set_valid (sw_set_valid),
        .sw_set_bits  (sw_set_bits),
        .sw_call_en   (sw_call_en),
        .pending      (pending)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_clr(input logic [15:0] bits);
        clr_bit = bits;
        tick(1);
        clr_bit = '0;
    endtask

    task automatic flush();
        ext_irq_n = '1;
        int_irq   = '0;
        tick(4);
        clr_all = 1'b1;
        tick(1);
        clr_all = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        check("R1 during reset", pending, 16'h0000);
        rst = 1'b0;
        tick(1);
        check("R1 after reset", pending, 16'h0000);
    endtask

    task automatic t_level_ext();
        edge_mode = 1'b0;
        ext_irq_n[9] = 1'b0;
        tick(2);
        check("R2 not yet set", pending, 16'h0000);
        tick(1);
        check("R2 set on third edge", pending, 16'h0200);
        pulse_clr(16'h0200);
        check("R6 cleared", pending, 16'h0000);
        tick(1);
        check("R2 relatched while low", pending, 16'h0200);
        flush();
    endtask

    task automatic t_edge_ext();
        edge_mode = 1'b1;
        ext_irq_n[10] = 1'b0;
        tick(3);
        check("R3 edge sets bit", pending, 16'h0400);
        pulse_clr(16'h0400);
        tick(3);
        check("R3 held low no relatch", pending, 16'h0000);
        ext_irq_n[10] = 1'b1;
        tick(3);
        ext_irq_n[10] = 1'b0;
        tick(3);
        check("R3 new edge sets again", pending, 16'h0400);
        ext_irq_n[10] = 1'b1;
        tick(3);
        ext_irq_n[10] = 1'b0;
        tick(3);
        ext_irq_n[10] = 1'b1;
        tick(3);
        pulse_clr(16'h0400);
        tick(3);
        check("R4 edge during pending discarded", pending, 16'h0000);
        flush();
    endtask

    task automatic t_internal();
        edge_mode = 1'b1;
        int_irq[3] = 1'b1;
        tick(1);
        check("R5 internal next edge", pending, 16'h0008);
        pulse_clr(16'h0008);
        check("R5 cleared", pending, 16'h0000);
        tick(1);
        check("R5 level in edge mode", pending, 16'h0008);
        flush();
    endtask

    task automatic t_clear_wins();
        int_irq[4] = 1'b1;
        clr_bit    = 16'h0010;
        tick(2);
        check("R8 hw set vs clear", pending, 16'h0000);
        int_irq[4] = 1'b0;
        clr_bit    = '0;
        sw_set_valid = 1'b1;
        sw_set_bits  = 16'h1000;
        clr_all      = 1'b1;
        tick(1);
        sw_set_valid = 1'b0;
        clr_all      = 1'b0;
        check("R8 sw set vs clear", pending, 16'h0000);
        flush();
    endtask

    task automatic t_sw_and_clears();
        sw_set_valid = 1'b1;
        sw_set_bits  = 16'h8101;
        tick(1);
        sw_set_valid = 1'b0;
        check("R9 sw set", pending, 16'h8101);
        sw_set_valid = 1'b1;
        sw_set_bits  = 16'h0202;
        tick(1);
        sw_set_valid = 1'b0;
        check("R9 sw set ORs", pending, 16'h8303);
        pulse_clr(16'h0101);
        check("R6 selective clear", pending, 16'h8202);
        clr_all = 1'b1;
        tick(1);
        clr_all = 1'b0;
        check("R7 global clear", pending, 16'h0000);
    endtask

    task automatic t_call_bit();
        sw_call_en   = 1'b0;
        sw_set_valid = 1'b1;
        sw_set_bits  = 16'h0020;
        tick(1);
        sw_set_valid = 1'b0;
        check("R10 bit5 blocked", pending, 16'h0000);
        sw_call_en   = 1'b1;
        sw_set_valid = 1'b1;
        tick(1);
        sw_set_valid = 1'b0;
        check("R10 bit5 allowed", pending, 16'h0020);
        sw_call_en = 1'b0;
        flush();
    endtask

    task automatic t_unused_lines();
        edge_mode    = 1'b0;
        ext_irq_n[2] = 1'b0;
        int_irq[8]   = 1'b1;
        tick(4);
        check("R11 stray inputs ignored", pending, 16'h0000);
        flush();
    endtask

    initial begin
        tick(3);
        t_reset();
        t_level_ext();
        t_edge_ext();
        t_internal();
        t_clear_wins();
        t_sw_and_clears();
        t_call_bit();
        t_unused_lines();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule